// File: doc/BRIEF.md
# Palette Host Access Port

This block is the processor-facing side of a color palette. A host reaches the palette RAM and a small set of control registers over an 8-bit data path. There are two active-low chip enables, a read/write strobe and a 3-bit operation selector. A transfer opens when either enable goes low. The block brings the enables, the strobe and the blanking input into the system clock, and finds the opening edge synchronously. On that edge it captures the strobe, the selector and the data. It then steers the transfer to the address pointer, the palette or a control register.

A palette entry is 24 bits wide. It moves as three byte transfers in red, green, blue order, at a 13-bit address that steps forward after each blue byte. A completed write entry goes into a single pending slot. The entry is committed to the palette RAM only while the active-low blanking input is low. If blanking is not active, the entry waits for the next blanking interval.

The data bus is split into pad-side input, output and output-enable signals. The palette RAM and the pixel lookup path sit outside this block.

Top module: `pal_host_port`

## Requirements
- R1: A transfer opens when the AND of `cs_a_ni` and `cs_b_ni` goes from 1 to 0. Either enable alone opens it. While both enables stay high, no register changes and the bus is not driven.
- R2: `rnw_i`, `sel_i` and `data_i` are captured when the transfer opens. Later changes to them during the same transfer have no effect.
- R3: A captured `rnw_i` of 1 is a read, which drives the bus. A captured 0 is a write, which never drives the bus.
- R4: Selector 0 writes the low 8 address bits. Selector 1 writes the high 5 address bits from `data_i[4:0]`; bits 7:5 are ignored. Reads return the low byte, and the high bits zero-extended to 8 bits.
- R5: Selector 2 writes take three bytes in the order red, green, blue. The blue byte completes the entry, and the address then steps by one, wrapping from 0x1FFF to 0.
- R6: Selector 2 reads return bytes of `pal_rdata_i` at `pal_raddr_o`, in this order: bits 23:16, then 15:8, then 7:0. The address steps by one after the third byte.
- R7: Any address write (selector 0 or 1) restarts the byte sequence at red.
- R8: A completed entry is committed only while the synchronized `blank_ni` is low. The commit is a one-cycle `pal_we_o` pulse, with `pal_waddr_o` set to the address at completion and `pal_wdata_o` = {red, green, blue}.
- R9: While blanking is inactive, a completed entry stays pending and is committed once `blank_ni` goes low. A newer completed entry replaces an uncommitted one.
- R10: Selectors 3 to 7 access five 8-bit control registers. They read back as written. Register `s` is visible on `ctrl_o[8*(s-3) +: 8]`, and all of them reset to 0.
- R11: `data_oe_o` is high only during a read transfer while the synchronized enable is low. It drops one clock after the synchronized enable returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_a_ni | input | 1 | Chip enable A, active low |
| cs_b_ni | input | 1 | Chip enable B, active low |
| rnw_i | input | 1 | 1 = read, 0 = write |
| sel_i | input | 3 | Operation selector |
| data_i | input | 8 | Host data into the block |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Pad output enable for data_o |
| blank_ni | input | 1 | Blanking interval, active low |
| pal_rdata_i | input | 24 | Palette RAM read data at pal_raddr_o |
| pal_raddr_o | output | 13 | Palette RAM read address |
| pal_we_o | output | 1 | Palette RAM write strobe |
| pal_waddr_o | output | 13 | Palette RAM write address |
| pal_wdata_o | output | 24 | Palette RAM write data |
| ctrl_o | output | 40 | Control register contents |

## Verification
The assertions rely on four assumptions about the inputs:
- `rnw_i` is settled at least two clocks before an enable falls.
- `sel_i` and `data_i` stay steady for at least three clocks after the fall, until they are captured.
- Each enable level is held for several clocks, so the synchronizer never misses an edge.
- The palette RAM model returns read data combinationally from `pal_raddr_o`.

The stimulus keeps to these assumptions. It sets the strobe, selector and data four clocks before lowering an enable, and holds the enable low for six clocks. It changes the selector and data only after that. It then keeps both enables high for six clocks before the next transfer.

// File: rtl/pal_host_pkg.sv
package pal_host_pkg;
  localparam int BUS_W      = 8;
  localparam int SEL_W      = 3;
  localparam int PAL_ADDR_W = 13;

  localparam logic [SEL_W-1:0] SEL_ADDR_LO   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR_HI   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PAL       = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CTRL_BASE = 3'd3;

  typedef struct packed {
    logic             rnw;
    logic [SEL_W-1:0] sel;
    logic [BUS_W-1:0] data;
  } host_req_t;
endpackage

// File: rtl/pal_host_sync.sv
module pal_host_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pal_host_cycle.sv
module pal_host_cycle
  import pal_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ns_i,
  input  logic             rnw_s_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             req_vld_o,
  output host_req_t        req_o,
  output logic             oe_o
);
  logic cs_d_q;
  logic start;

  assign start = cs_d_q & ~cs_ns_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q    <= 1'b1;
      req_vld_o <= 1'b0;
      req_o     <= '0;
      oe_o      <= 1'b0;
    end else begin
      cs_d_q    <= cs_ns_i;
      req_vld_o <= start;
      if (start) begin
        req_o.rnw  <= rnw_s_i;
        req_o.sel  <= sel_i;
        req_o.data <= data_i;
      end
      if (cs_ns_i)                     oe_o <= 1'b0;
      else if (req_vld_o && req_o.rnw) oe_o <= 1'b1;
    end
  end

  AST_START_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !oe_o); // R11
  AST_RELEASE_ON_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ns_i |=> !oe_o); // R11
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> $stable(req_o)); // R2
  AST_OE_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> req_o.rnw); // R3
endmodule

// File: rtl/pal_host_regs.sv
module pal_host_regs
  import pal_host_pkg::*;
#(
  parameter int ADDR_W   = PAL_ADDR_W,
  localparam int HI_W    = ADDR_W - BUS_W,
  localparam int ENTRY_W = 3 * BUS_W,
  localparam int NUM_CTRL = (1 << SEL_W) - int'(SEL_CTRL_BASE)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_vld_i,
  input  host_req_t                 req_i,
  input  logic                      blank_act_i,
  input  logic [ENTRY_W-1:0]        pal_rdata_i,
  output logic [BUS_W-1:0]          rd_data_o,
  output logic [ADDR_W-1:0]         pal_raddr_o,
  output logic                      pal_we_o,
  output logic [ADDR_W-1:0]         pal_waddr_o,
  output logic [ENTRY_W-1:0]        pal_wdata_o,
  output logic [NUM_CTRL*BUS_W-1:0] ctrl_o
);
  logic [ADDR_W-1:0]  addr_q;
  logic [1:0]         comp_q;
  logic [BUS_W-1:0]   red_q, grn_q;
  logic               pend_q;
  logic [ADDR_W-1:0]  pend_addr_q;
  logic [ENTRY_W-1:0] pend_data_q;
  logic [BUS_W-1:0]   ctrl_q [NUM_CTRL];

  logic is_wr, is_rd, addr_wr, pal_acc, last_comp, entry_done;
  logic [BUS_W-1:0] rd_next, pal_byte;
  logic [SEL_W-1:0] ctrl_idx;

  assign is_wr      = req_vld_i & ~req_i.rnw;
  assign is_rd      = req_vld_i &  req_i.rnw;
  assign addr_wr    = is_wr & ((req_i.sel == SEL_ADDR_LO) | (req_i.sel == SEL_ADDR_HI));
  assign pal_acc    = req_vld_i & (req_i.sel == SEL_PAL);
  assign last_comp  = (comp_q == 2'd2);
  assign entry_done = pal_acc & ~req_i.rnw & last_comp;
  assign ctrl_idx   = req_i.sel - SEL_CTRL_BASE;

  always_comb begin
    case (comp_q)
      2'd0:    pal_byte = pal_rdata_i[3*BUS_W-1:2*BUS_W];
      2'd1:    pal_byte = pal_rdata_i[2*BUS_W-1:BUS_W];
      default: pal_byte = pal_rdata_i[BUS_W-1:0];
    endcase
  end

  always_comb begin
    case (req_i.sel)
      SEL_ADDR_LO: rd_next = addr_q[BUS_W-1:0];
      SEL_ADDR_HI: rd_next = BUS_W'(addr_q[ADDR_W-1:BUS_W]);
      SEL_PAL:     rd_next = pal_byte;
      default:     rd_next = ctrl_q[ctrl_idx];
    endcase
  end

  // address pointer and byte sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      comp_q <= '0;
      red_q  <= '0;
      grn_q  <= '0;
    end else if (is_wr && req_i.sel == SEL_ADDR_LO) begin
      addr_q[BUS_W-1:0] <= req_i.data;
      comp_q            <= '0;
    end else if (is_wr && req_i.sel == SEL_ADDR_HI) begin
      addr_q[ADDR_W-1:BUS_W] <= req_i.data[HI_W-1:0];
      comp_q                 <= '0;
    end else if (pal_acc) begin
      if (!req_i.rnw && comp_q == 2'd0) red_q <= req_i.data;
      if (!req_i.rnw && comp_q == 2'd1) grn_q <= req_i.data;
      if (last_comp) begin
        comp_q <= '0;
        addr_q <= addr_q + 1'b1;
      end else begin
        comp_q <= comp_q + 1'b1;
      end
    end
  end

  // single pending entry, committed during blanking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (entry_done) begin
      pend_q      <= 1'b1;
      pend_addr_q <= addr_q;
      pend_data_q <= {red_q, grn_q, req_i.data};
    end else if (pal_we_o) begin
      pend_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q[k] <= '0;
      else if (is_wr && req_i.sel == SEL_W'(int'(SEL_CTRL_BASE) + k)) ctrl_q[k] <= req_i.data;
    end
    assign ctrl_o[k*BUS_W +: BUS_W] = ctrl_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_data_o <= '0;
    else if (is_rd) rd_data_o <= rd_next;
  end

  assign pal_raddr_o = addr_q;
  assign pal_we_o    = pend_q & blank_act_i;
  assign pal_waddr_o = pend_addr_q;
  assign pal_wdata_o = pend_data_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_acc && last_comp) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1))); // R5
  AST_SEQ_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_wr |=> (comp_q == 2'd0)); // R7
  AST_COMMIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_we_o && !entry_done) |=> !pend_q); // R8
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !blank_act_i && !entry_done) |=>
      (pend_q && $stable(pend_data_q) && $stable(pend_addr_q))); // R9
endmodule

// File: rtl/pal_host_port.sv
module pal_host_port
  import pal_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_a_ni,
  input  logic                  cs_b_ni,
  input  logic                  rnw_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [BUS_W-1:0]      data_i,
  output logic [BUS_W-1:0]      data_o,
  output logic                  data_oe_o,
  input  logic                  blank_ni,
  input  logic [3*BUS_W-1:0]    pal_rdata_i,
  output logic [PAL_ADDR_W-1:0] pal_raddr_o,
  output logic                  pal_we_o,
  output logic [PAL_ADDR_W-1:0] pal_waddr_o,
  output logic [3*BUS_W-1:0]    pal_wdata_o,
  output logic [5*BUS_W-1:0]    ctrl_o
);
  logic [2:0] sync_d, sync_q;
  logic       cs_ns, rnw_s, blank_ns;
  logic       req_vld;
  host_req_t  req;

  assign sync_d = {cs_a_ni & cs_b_ni, rnw_i, blank_ni};

  pal_host_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign {cs_ns, rnw_s, blank_ns} = sync_q;

  pal_host_cycle u_cyc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ns_i  (cs_ns),
    .rnw_s_i  (rnw_s),
    .sel_i    (sel_i),
    .data_i   (data_i),
    .req_vld_o(req_vld),
    .req_o    (req),
    .oe_o     (data_oe_o)
  );

  pal_host_regs #(.ADDR_W(PAL_ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_vld_i  (req_vld),
    .req_i      (req),
    .blank_act_i(~blank_ns),
    .pal_rdata_i(pal_rdata_i),
    .rd_data_o  (data_o),
    .pal_raddr_o(pal_raddr_o),
    .pal_we_o   (pal_we_o),
    .pal_waddr_o(pal_waddr_o),
    .pal_wdata_o(pal_wdata_o),
    .ctrl_o     (ctrl_o)
  );

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ns && $past(cs_ns)) |-> !data_oe_o); // R1
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we_o |-> !blank_ns); // R8
endmodule

// File: tb/pal_host_port_tb_top.sv
`timescale 1ns/1ps
module pal_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_a_n = 1'b1, cs_b_n = 1'b1, rnw = 1'b0, blank_n = 1'b1;
  logic [2:0]  sel = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe, we;
  logic [23:0] rdata, wdata;
  logic [12:0] raddr, waddr;
  logic [39:0] ctrl;

  int total = 0, bad = 0, commits = 0;
  bit done_flag = 0;

  logic [12:0] m_addr = '0;
  int          m_comp = 0;
  logic [7:0]  m_r = '0, m_g = '0;
  logic [7:0]  m_ctrl [5] = '{default: 8'h00};
  bit          exp_vld = 0;
  logic [12:0] exp_addr;
  logic [23:0] exp_data;

  always #2.5 clk = ~clk;

  function automatic logic [23:0] rom_f(input logic [12:0] a);
    return {a[7:0] ^ 8'h5A, 3'b101, a[12:8], ~a[7:0]};
  endfunction

  assign rdata = rom_f(raddr);

  pal_host_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_a_ni(cs_a_n), .cs_b_ni(cs_b_n),
    .rnw_i(rnw), .sel_i(sel), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .blank_ni(blank_n), .pal_rdata_i(rdata), .pal_raddr_o(raddr),
    .pal_we_o(we), .pal_waddr_o(waddr), .pal_wdata_o(wdata), .ctrl_o(ctrl)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // commit monitor: R8/R9
  always @(negedge clk) begin
    if (rst_n && we) begin
      commits++;
      check("R8 commit expected", 40'(exp_vld), 40'd1);
      check("R8 waddr", 40'(waddr), 40'(exp_addr));
      check("R9 wdata", 40'(wdata), 40'(exp_data));
      exp_vld = 0;
    end
  end

  task automatic cs_drop(input int csm);
    if (csm == 0)      cs_a_n = 1'b0;
    else if (csm == 1) cs_b_n = 1'b0;
    else begin cs_a_n = 1'b0; cs_b_n = 1'b0; end
  endtask

  task automatic host_write(input logic [2:0] s, input logic [7:0] d, input int csm);
    if (s == 3'd0) begin m_addr[7:0] = d; m_comp = 0; end
    else if (s == 3'd1) begin m_addr[12:8] = d[4:0]; m_comp = 0; end
    else if (s == 3'd2) begin
      if (m_comp == 0) m_r = d;
      else if (m_comp == 1) m_g = d;
      else begin
        exp_vld = 1; exp_addr = m_addr; exp_data = {m_r, m_g, d};
        m_addr = m_addr + 1'b1;
      end
      m_comp = (m_comp == 2) ? 0 : m_comp + 1;
    end else m_ctrl[s - 3'd3] = d;
    rnw = 1'b0; sel = s; din = d;
    tick(4);
    cs_drop(csm);
    tick(6);
    check("R3 no drive on write", 40'(doe), 40'd0);
    din = 8'($urandom); sel = 3'($urandom);   // R2: late changes ignored
    cs_a_n = 1'b1; cs_b_n = 1'b1;
    tick(6);
  endtask

  task automatic host_read(input logic [2:0] s, input int csm, input string req);
    logic [7:0]  e;
    logic [23:0] ent;
    ent = rom_f(m_addr);
    if (s == 3'd0)      e = m_addr[7:0];
    else if (s == 3'd1) e = {3'b000, m_addr[12:8]};
    else if (s == 3'd2) e = (m_comp == 0) ? ent[23:16] : (m_comp == 1) ? ent[15:8] : ent[7:0];
    else                e = m_ctrl[s - 3'd3];
    rnw = 1'b1; sel = s; din = 8'($urandom);
    tick(4);
    cs_drop(csm);
    tick(6);
    check("R11 drive during read", 40'(doe), 40'd1);
    check(req, 40'(dout), 40'(e));
    cs_a_n = 1'b1; cs_b_n = 1'b1;
    tick(6);
    check("R11 released after enable high", 40'(doe), 40'd0);
    if (s == 3'd2) begin
      if (m_comp == 2) m_addr = m_addr + 1'b1;
      m_comp = (m_comp == 2) ? 0 : m_comp + 1;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // reset state
    check("R11 reset oe", 40'(doe), 40'd0);
    check("R10 reset ctrl", ctrl, 40'd0);
    check("R8 reset we", 40'(we), 40'd0);

    // R1 idle: both enables high, stimulus wiggles
    rnw = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sel = 3'($urandom); din = 8'($urandom); tick(3);
    end
    check("R1 idle ctrl untouched", ctrl, 40'd0);
    check("R1 idle no drive", 40'(doe), 40'd0);
    host_read(3'd0, 2, "R1 idle addr untouched");

    // R10 control regs via each enable
    host_write(3'd3, 8'hA1, 0);
    host_write(3'd7, 8'h7E, 1);
    host_write(3'd5, 8'h3C, 2);
    check("R10 ctrl_o map", ctrl, {8'h7E, 8'h00, 8'h3C, 8'h00, 8'hA1});
    host_read(3'd3, 1, "R1 R10 read via enable B");
    host_read(3'd7, 0, "R1 R10 read via enable A");

    // R4 address bytes, high bits ignored
    host_write(3'd0, 8'h34, 0);
    host_write(3'd1, 8'hF2, 1);
    host_read(3'd0, 0, "R4 addr low");
    host_read(3'd1, 0, "R4 addr high zero-extended");

    // R6 palette read sequence and step
    host_read(3'd2, 2, "R6 red byte");
    host_read(3'd2, 2, "R6 green byte");
    host_read(3'd2, 2, "R6 blue byte");
    host_read(3'd0, 0, "R6 address stepped");

    // R7 restart mid-sequence
    host_read(3'd2, 0, "R7 red before restart");
    host_write(3'd0, 8'h10, 0);
    host_read(3'd2, 0, "R7 red after restart");

    // R5/R8 write with blanking active, wrap at top
    blank_n = 1'b0;
    host_write(3'd0, 8'hFF, 0);
    host_write(3'd1, 8'h1F, 0);
    c0 = commits;
    host_write(3'd2, 8'h11, 0);
    host_write(3'd2, 8'h22, 1);
    host_write(3'd2, 8'h33, 2);
    check("R8 one commit in blanking", 40'(commits - c0), 40'd1);
    host_read(3'd0, 0, "R5 wrap low");
    host_read(3'd1, 0, "R5 wrap high");

    // R9 pending outside blanking, newer entry replaces
    blank_n = 1'b1;
    tick(6);
    c0 = commits;
    host_write(3'd0, 8'h40, 0);
    host_write(3'd2, 8'h01, 0); host_write(3'd2, 8'h02, 0); host_write(3'd2, 8'h03, 0);
    tick(10);
    check("R9 held while not blanking", 40'(commits - c0), 40'd0);
    host_write(3'd2, 8'h04, 1); host_write(3'd2, 8'h05, 1); host_write(3'd2, 8'h06, 1);
    check("R9 still held", 40'(commits - c0), 40'd0);
    blank_n = 1'b0;
    tick(8);
    check("R9 single commit on blanking", 40'(commits - c0), 40'd1);

    // R2 late change ignored (host_write scrambles after capture)
    host_write(3'd4, 8'h99, 0);
    host_read(3'd4, 0, "R2 captured value kept");

    // random mix, blanking active
    for (int i = 0; i < 250; i++) begin
      int op = int'($urandom_range(0, 9));
      int cm = int'($urandom_range(0, 2));
      logic [2:0] s = 3'($urandom_range(3, 7));
      case (op)
        0: host_write(3'd0, 8'($urandom), cm);
        1: host_write(3'd1, 8'($urandom), cm);
        2, 3, 4: host_write(3'd2, 8'($urandom), cm);
        5: host_write(s, 8'($urandom), cm);
        6: host_read(s, cm, "R10 random ctrl read");
        7: host_read(3'd2, cm, "R6 random palette read");
        8: host_read(3'd0, cm, "R4 random addr low read");
        default: host_read(3'd1, cm, "R4 random addr high read");
      endcase
    end
    tick(8);
    check("R8 nothing left pending", 40'(exp_vld), 40'd0);
    check("R10 final ctrl_o", ctrl, {m_ctrl[4], m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]});

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule